// File: doc/BRIEF.md
# Fast PWM Timer with Buffered Compare

This block is a single-slope PWM timer. A 16-bit counter advances by one on each cycle where an external prescaler raises a tick enable. It returns to zero on the tick after it reaches a selectable TOP value. Three compare channels each drive a PWM pin that is set when the counter wraps to zero and cleared on a compare match. Each pin can be non-inverted, inverted, or held low.

TOP comes from one of three sources. The first is a fixed 8, 9 or 10-bit limit. The second is compare channel 0, which is double buffered: a new value reaches the comparator only at a TOP restart, so the period can be changed safely while the timer runs. The third is a capture register, which is not buffered. A write to it acts at once, and if the new value is below the current count, the counter runs on to 0xFFFF and wraps before the new TOP can match.

Software configures the timer through a write-only port. The register addresses are: 0 control, 1 to 3 compare channels 0 to 2, 4 capture, and 5 flag clear. The overflow, compare and capture-as-TOP flags are visible on output pins. Each flag is cleared by writing a one to its bit.

Top module: `fpwm_timer`

## Requirements
- R1: On every tick the counter increments by one, wrapping 0xFFFF to 0x0000. On a tick where the counter equals TOP, the counter becomes 0 instead and the overflow flag is set. After reset the counter, all flags and all PWM pins are 0.
- R2: When TOP is taken from the capture register, the capture flag is set on the same tick as the overflow flag. When TOP is taken from compare channel 0, the compare-0 flag is set on that tick.
- R3: A write to compare channel 0 (address 1) goes to a buffer. The active compare value is loaded from the buffer only on a tick where the counter clears at TOP.
- R4: A write to the capture register (address 4) takes effect on the next cycle. If the value is below the current count, the counter continues to 0xFFFF and wraps to 0 without setting the overflow flag, and then clears at the new TOP.
- R5: Compare flag n (flag bit n+1) is set on every tick where the counter equals channel n's active compare value. A compare value above TOP never sets the flag.
- R6: While a fixed-TOP mode is active, a value written to a compare register has its bits above the resolution forced to zero. The capture register is never masked.
- R7: Output mode field m of channel n sits in control bits [4+2n:3+2n]. Mode 2 drives the internal waveform: high from a wrap to zero, low from the tick after a match, with the set winning when both fall on one tick. Mode 3 drives its complement. Modes 0 and 1 hold the pin low.
- R8: The counter, flags, waveform state and buffer load change only on cycles with the tick high. Register writes are accepted on any cycle, including cycles with the tick low.
- R9: Writing address 5 clears each flag whose bit is one: bit 0 overflow, bits 1 to 3 compare channels 0 to 2, bit 4 capture. A set event on the same cycle wins over the clear.
- R10: Control bits [2:0] select TOP: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives compare channel 0's active value, 4 gives the capture register. Codes 5 to 7 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timer clock enable from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| count_o | output | 16 | Current counter value |
| ovf_flag_o | output | 1 | Overflow flag (counter cleared at TOP) |
| cmp_flag_o | output | 3 | Compare match flags, one per channel |
| cap_flag_o | output | 1 | Capture-as-TOP flag |
| pwm_o | output | 3 | PWM output pins |

## Verification
The properties assume that the tick enable and the write port change only between clock edges. They also assume that the control register and a compare register are not written on the same cycle, because the masking decision uses the mode held before the write. The stimulus drives every input on the falling edge and issues one write per cycle, so both assumptions hold. It changes the TOP source only right after a restart, so that a mode switch does not push the count past the new TOP, except in the deliberate capture-below-count case. A bench model, evaluated on the same edges, checks the gated-tick phases cycle by cycle.

// File: rtl/fpwm_pkg.sv
// Package: shared register addresses and the TOP source encoding for the
// fast PWM timer. Assumes a 3-bit register address space.
package fpwm_pkg;

    typedef enum logic [2:0] {
        TOP_FIX8  = 3'd0,
        TOP_FIX9  = 3'd1,
        TOP_FIX10 = 3'd2,
        TOP_CMPA  = 3'd3,
        TOP_CAPT  = 3'd4
    } top_sel_e;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_CMP0  = 1;
    localparam int ADDR_CAPT  = 4;
    localparam int ADDR_FLAGS = 5;

    localparam int MODE_LSB   = 3;

    // Map a raw control code onto a TOP source; unused codes fall back to 8-bit.
    function automatic top_sel_e decode_top(input logic [2:0] code);
        case (code)
            3'd1:    return TOP_FIX9;
            3'd2:    return TOP_FIX10;
            3'd3:    return TOP_CMPA;
            3'd4:    return TOP_CAPT;
            default: return TOP_FIX8;
        endcase
    endfunction

endpackage

// File: rtl/fpwm_regs.sv
// Register file of the fast PWM timer: control, compare channels and the
// capture register. Channel 0 is double buffered and loads its active value
// only when load_i is high (a tick at TOP); the other channels and the capture
// register act immediately. Compare writes are masked to the fixed resolution
// while a fixed-TOP mode is active. Assumes one write per cycle.
module fpwm_regs
    import fpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              wr_addr_i,
    input  logic [CNT_W-1:0]               wr_data_i,
    input  logic                           load_i,
    output top_sel_e                       top_sel_o,
    output logic [NUM_CH-1:0][1:0]         out_mode_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_act_o,
    output logic [CNT_W-1:0]               cap_val_o
);

    localparam int CTRL_W = MODE_LSB + 2 * NUM_CH;
    localparam logic [CNT_W-1:0] MASK8  = CNT_W'(2**8 - 1);
    localparam logic [CNT_W-1:0] MASK9  = CNT_W'(2**9 - 1);
    localparam logic [CNT_W-1:0] MASK10 = CNT_W'(2**10 - 1);

    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  wr_mask;
    logic              wr_ctrl;
    logic              wr_capt;

    assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
    assign wr_capt = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CAPT));
    assign top_sel_o = decode_top(ctrl_q[2:0]);

    // Resolution mask applied to compare writes under the current TOP mode.
    always_comb begin
        case (top_sel_o)
            TOP_FIX9:  wr_mask = MASK9;
            TOP_FIX10: wr_mask = MASK10;
            TOP_CMPA,
            TOP_CAPT:  wr_mask = '1;
            default:   wr_mask = MASK8;
        endcase
    end

    // Control register holding the TOP select and per-channel output modes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= wr_data_i[CTRL_W-1:0];
    end

    // Capture register: unbuffered, never masked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_val_o <= '0;
        else if (wr_capt)
            cap_val_o <= wr_data_i;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic wr_cmp;
        assign wr_cmp = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CMP0 + ch));
        assign out_mode_o[ch] = ctrl_q[MODE_LSB + 2*ch +: 2];

        if (ch == 0) begin : g_buffered
            logic [CNT_W-1:0] buf_q;
            logic [CNT_W-1:0] act_q;

            // Buffer catches every write to channel 0.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    buf_q <= '0;
                else if (wr_cmp)
                    buf_q <= wr_data_i & wr_mask;
            end

            // Active value follows the buffer only at a TOP restart.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    act_q <= '0;
                else if (load_i)
                    act_q <= buf_q;
            end

            assign cmp_act_o[ch] = act_q;
        end else begin : g_direct
            logic [CNT_W-1:0] val_q;

            // Unbuffered compare value for the remaining channels.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    val_q <= '0;
                else if (wr_cmp)
                    val_q <= wr_data_i & wr_mask;
            end

            assign cmp_act_o[ch] = val_q;
        end
    end

endmodule

// File: rtl/fpwm_counter.sv
// Up-counter of the fast PWM timer with TOP selection. Counts one per tick,
// returns to zero on the tick where it equals TOP, and otherwise rolls over
// from all-ones to zero. Assumes CNT_W is at least 10.
module fpwm_counter
    import fpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  top_sel_e         top_sel_i,
    input  logic [CNT_W-1:0] cmpa_i,
    input  logic [CNT_W-1:0] cap_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] top_o,
    output logic             at_top_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] TOP8  = CNT_W'(2**8 - 1);
    localparam logic [CNT_W-1:0] TOP9  = CNT_W'(2**9 - 1);
    localparam logic [CNT_W-1:0] TOP10 = CNT_W'(2**10 - 1);

    // Select the TOP value for the present mode.
    always_comb begin
        case (top_sel_i)
            TOP_FIX9:  top_o = TOP9;
            TOP_FIX10: top_o = TOP10;
            TOP_CMPA:  top_o = cmpa_i;
            TOP_CAPT:  top_o = cap_i;
            default:   top_o = TOP8;
        endcase
    end

    assign at_top_o = (cnt_o == top_o);
    assign wrap_o   = at_top_o || (&cnt_o);

    // Count on each tick; restart from zero after TOP.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (tick_i)
            cnt_o <= at_top_o ? '0 : cnt_o + 1'b1;
    end

endmodule

// File: rtl/fpwm_channel.sv
// One compare channel: match flag with write-one-to-clear, the single-slope
// waveform state and the output mode mux. The set from a wrap wins over a
// clear from a match on the same tick; a flag set wins over its clear.
module fpwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             wrap_i,
    input  logic [1:0]       mode_i,
    input  logic             clr_i,
    output logic             flag_o,
    output logic             pin_o
);

    logic match;
    logic wave_q;

    assign match = (cnt_i == cmp_i);

    // Match flag: set on a matching tick, else cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (tick_i && match)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    // Waveform: high from the wrap to zero, low after the match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wave_q <= 1'b0;
        else if (tick_i) begin
            if (wrap_i)
                wave_q <= 1'b1;
            else if (match)
                wave_q <= 1'b0;
        end
    end

    // Output mode: 2 non-inverted, 3 inverted, others held low.
    always_comb begin
        case (mode_i)
            2'd2:    pin_o = wave_q;
            2'd3:    pin_o = ~wave_q;
            default: pin_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpwm_timer.sv
// Top of the fast PWM timer: register file, counter, compare channels and the
// overflow and capture-as-TOP flags. Counter, flag and buffer updates happen
// only on ticks; writes are accepted on any cycle.
module fpwm_timer
    import fpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_flag_o,
    output logic [NUM_CH-1:0] cmp_flag_o,
    output logic              cap_flag_o,
    output logic [NUM_CH-1:0] pwm_o
);

    localparam int FLAG_W = NUM_CH + 2;

    top_sel_e                      top_sel;
    logic [NUM_CH-1:0][1:0]        out_mode;
    logic [NUM_CH-1:0][CNT_W-1:0]  cmp_act;
    logic [CNT_W-1:0]              cap_val;
    logic [CNT_W-1:0]              top_val;
    logic                          at_top;
    logic                          wrap;
    logic                          restart;
    logic [FLAG_W-1:0]             flag_clr;

    assign restart  = tick_i && at_top;
    assign flag_clr = (wr_en_i && (wr_addr_i == ADDR_W'(ADDR_FLAGS)))
                      ? wr_data_i[FLAG_W-1:0] : '0;

    fpwm_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .load_i     (restart),
        .top_sel_o  (top_sel),
        .out_mode_o (out_mode),
        .cmp_act_o  (cmp_act),
        .cap_val_o  (cap_val)
    );

    fpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .top_sel_i (top_sel),
        .cmpa_i    (cmp_act[0]),
        .cap_i     (cap_val),
        .cnt_o     (count_o),
        .top_o     (top_val),
        .at_top_o  (at_top),
        .wrap_o    (wrap)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        fpwm_channel #(.CNT_W(CNT_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .cnt_i  (count_o),
            .cmp_i  (cmp_act[ch]),
            .wrap_i (wrap),
            .mode_i (out_mode[ch]),
            .clr_i  (flag_clr[ch+1]),
            .flag_o (cmp_flag_o[ch]),
            .pin_o  (pwm_o[ch])
        );
    end

    // Overflow flag: set at each TOP restart, set wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_flag_o <= 1'b0;
        else if (restart)
            ovf_flag_o <= 1'b1;
        else if (flag_clr[0])
            ovf_flag_o <= 1'b0;
    end

    // Capture flag: set at a restart while the capture register is TOP.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_flag_o <= 1'b0;
        else if (restart && (top_sel == TOP_CAPT))
            cap_flag_o <= 1'b1;
        else if (flag_clr[FLAG_W-1])
            cap_flag_o <= 1'b0;
    end

endmodule

// File: rtl/fpwm_checker.sv
// Property checker for the fast PWM timer, attached to every instance of the
// top by the bind below. Assumes inputs change away from the clock edge.
module fpwm_checker
    import fpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tick_i,
    input logic [CNT_W-1:0]              count_o,
    input logic                          ovf_flag_o,
    input logic                          cap_flag_o,
    input logic [NUM_CH-1:0]             pwm_o,
    input logic [CNT_W-1:0]              top_val,
    input logic                          at_top,
    input top_sel_e                      top_sel,
    input logic [CNT_W-1:0]              cmpa_act,
    input logic [NUM_CH-1:0][1:0]        out_mode,
    input logic                          ovf_clr
);

    AST_CLEAR_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && count_o == top_val) |=> (count_o == '0 && ovf_flag_o)); // R1

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && count_o != top_val) |=> (count_o == $past(count_o) + 1'b1)); // R1

    AST_OVF_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag_o) |-> $past(tick_i && at_top)); // R1

    AST_CAPT_WITH_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && at_top && top_sel == TOP_CAPT) |=> (cap_flag_o && ovf_flag_o)); // R2

    AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && at_top) |=> $stable(cmpa_act)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(count_o) && $stable(pwm_o))); // R8

    AST_CLEAR_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !(tick_i && at_top)) |=> !ovf_flag_o); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && tick_i && at_top) |=> ovf_flag_o); // R9

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pin
        AST_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (out_mode[ch] < 2'd2) |-> !pwm_o[ch]); // R7
    end

endmodule

bind fpwm_timer fpwm_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .count_o    (count_o),
    .ovf_flag_o (ovf_flag_o),
    .cap_flag_o (cap_flag_o),
    .pwm_o      (pwm_o),
    .top_val    (top_val),
    .at_top     (at_top),
    .top_sel    (top_sel),
    .cmpa_act   (cmp_act[0]),
    .out_mode   (out_mode),
    .ovf_clr    (flag_clr[0])
);

// File: tb/sim_fpwm_timer.sv
module sim_fpwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] count_o;
    logic        ovf_flag_o;
    logic [2:0]  cmp_flag_o;
    logic        cap_flag_o;
    logic [2:0]  pwm_o;

    int n_checks = 0;
    int n_errors = 0;
    int tick_mode = 0;
    bit chk_on = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    fpwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .count_o(count_o),
        .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o),
        .cap_flag_o(cap_flag_o), .pwm_o(pwm_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Tick generator: 0 always on, 1 pseudo-random, 2 always off.
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick_i <= (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? lfsr[0] : 1'b0;
    end

    // Behavioural reference model.
    int m_cnt, m_ctrl, m_buf0, m_act0, m_cap, m_top, m_mask, m_sel, m_cv;
    int m_cmp[3];
    bit m_ovf, m_capf, m_attop, m_wrap;
    bit m_cf[3];
    bit m_pq[3];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ctrl = 0; m_buf0 = 0; m_act0 = 0; m_cap = 0;
            m_ovf = 0; m_capf = 0;
            for (int i = 0; i < 3; i++) begin m_cmp[i] = 0; m_cf[i] = 0; m_pq[i] = 0; end
        end else begin
            m_sel = m_ctrl & 7;
            case (m_sel)
                1: begin m_top = 511;  m_mask = 511;   end
                2: begin m_top = 1023; m_mask = 1023;  end
                3: begin m_top = m_act0; m_mask = 65535; end
                4: begin m_top = m_cap;  m_mask = 65535; end
                default: begin m_top = 255; m_mask = 255; end
            endcase
            m_attop = (m_cnt == m_top);
            m_wrap = m_attop || (m_cnt == 65535);
            if (wr_en_i && wr_addr_i == 5) begin
                if (wr_data_i[0]) m_ovf = 0;
                for (int i = 0; i < 3; i++) if (wr_data_i[i+1]) m_cf[i] = 0;
                if (wr_data_i[4]) m_capf = 0;
            end
            if (tick_i) begin
                for (int i = 0; i < 3; i++) begin
                    m_cv = (i == 0) ? m_act0 : m_cmp[i];
                    if (m_cnt == m_cv) m_cf[i] = 1;
                    if (m_wrap) m_pq[i] = 1;
                    else if (m_cnt == m_cv) m_pq[i] = 0;
                end
                if (m_attop) begin
                    m_ovf = 1;
                    if (m_sel == 4) m_capf = 1;
                    m_act0 = m_buf0;
                end
                m_cnt = m_attop ? 0 : ((m_cnt + 1) & 65535);
            end
            if (wr_en_i) begin
                case (wr_addr_i)
                    0: m_ctrl = wr_data_i & 16'h01FF;
                    1: m_buf0 = wr_data_i & m_mask;
                    2: m_cmp[1] = wr_data_i & m_mask;
                    3: m_cmp[2] = wr_data_i & m_mask;
                    4: m_cap = wr_data_i;
                    default: ;
                endcase
            end
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (chk_on) begin
            chk(count_o == m_cnt[15:0], "R1 count vs model", count_o, m_cnt);
            chk(ovf_flag_o == m_ovf, "R1 overflow flag vs model", ovf_flag_o, m_ovf);
            chk(cap_flag_o == m_capf, "R2 capture flag vs model", cap_flag_o, m_capf);
            for (int i = 0; i < 3; i++) begin
                int md;
                bit e;
                md = (m_ctrl >> (3 + 2*i)) & 3;
                e = (md == 2) ? m_pq[i] : (md == 3) ? !m_pq[i] : 1'b0;
                chk(cmp_flag_o[i] == m_cf[i], "R5 compare flag vs model", cmp_flag_o[i], m_cf[i]);
                chk(pwm_o[i] == e, "R7 pwm pin vs model", pwm_o[i], e);
            end
        end
    end

    task automatic wr(input int addr, input int data);
        wr_en_i = 1'b1;
        wr_addr_i = addr[2:0];
        wr_data_i = data[15:0];
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic wait_count(input int v);
        for (int k = 0; k < 80000; k++) begin
            if (count_o == v[15:0]) return;
            @(negedge clk);
        end
        chk(0, "wait_count timeout", count_o, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(count_o == 0 && ovf_flag_o == 0 && cmp_flag_o == 0 && cap_flag_o == 0,
            "R1 reset state", {cap_flag_o, cmp_flag_o, ovf_flag_o}, 0);
        chk(pwm_o == 0, "R1 reset pins", pwm_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1;

        // Fixed 8-bit; ch0 mode 2, ch1 mode 3, ch2 mode 0.
        wr(0, 16'h0070);
        wr(2, 16'h0040);
        wr(3, 16'h0080);
        wr(1, 16'h0020);
        wait_count(16'h00FF);
        @(negedge clk);
        chk(count_o == 0 && ovf_flag_o, "R10 8-bit TOP restart", count_o, 0);
        chk(pwm_o[2] == 0, "R7 mode 0 pin low", pwm_o[2], 0);
        wait_count(16'h0010);
        chk(pwm_o[0] == 1, "R7 non-inverted high before match", pwm_o[0], 1);
        chk(pwm_o[1] == 0, "R7 inverted low before match", pwm_o[1], 0);
        wait_count(16'h0050);
        chk(pwm_o[0] == 0, "R7 non-inverted low after match", pwm_o[0], 0);
        chk(pwm_o[1] == 1, "R7 inverted high after match", pwm_o[1], 1);
        wr(5, 16'h001F);
        chk(ovf_flag_o == 0 && cmp_flag_o == 0, "R9 write-one clears flags",
            {cmp_flag_o, ovf_flag_o}, 0);

        // Fixed 9-bit with a masked compare write.
        wr(0, 16'h0071);
        wr(2, 16'hFFFF);
        wr(5, 16'h001F);
        wait_count(16'h01FE);
        chk(cmp_flag_o[1] == 0, "R6 no match before masked value", cmp_flag_o[1], 0);
        @(negedge clk);
        @(negedge clk);
        chk(count_o == 0, "R10 9-bit TOP restart", count_o, 0);
        chk(cmp_flag_o[1] == 1, "R6 masked compare matches 0x1FF", cmp_flag_o[1], 1);

        // Fixed 10-bit, and stage 0x30 in channel 0's buffer.
        wr(0, 16'h0072);
        wr(1, 16'h0030);
        wait_count(16'h03FF);
        @(negedge clk);
        chk(count_o == 0, "R10 10-bit TOP restart", count_o, 0);

        // Channel 0 as TOP.
        wr(0, 16'h0073);
        wr(5, 16'h001F);
        wait_count(16'h0030);
        @(negedge clk);
        chk(count_o == 0 && ovf_flag_o, "R3 TOP from loaded buffer", count_o, 0);
        chk(cmp_flag_o[0] == 1, "R2 compare-0 flag with overflow", cmp_flag_o[0], 1);
        wait_count(16'h0020);
        wr(1, 16'h0010);
        wait_count(16'h0030);
        @(negedge clk);
        chk(count_o == 0, "R3 buffered write not used mid-period", count_o, 0);
        wait_count(16'h0010);
        @(negedge clk);
        chk(count_o == 0, "R3 new TOP after restart", count_o, 0);

        // Compare above TOP never matches.
        wr(3, 16'h0050);
        wr(5, 16'h001F);
        repeat (64) @(negedge clk);
        chk(cmp_flag_o[2] == 0, "R5 compare above TOP never matches", cmp_flag_o[2], 0);

        // Capture register as TOP.
        wr(4, 16'h0100);
        wait_count(16'h0001);
        wr(0, 16'h0074);
        wr(5, 16'h001F);
        wait_count(16'h0100);
        @(negedge clk);
        chk(count_o == 0 && cap_flag_o && ovf_flag_o, "R2 capture flag with overflow",
            {cap_flag_o, ovf_flag_o}, 3);
        wait_count(16'h0080);
        wr(4, 16'h0040);
        wr(5, 16'h001F);
        wait_count(16'hFFFF);
        chk(ovf_flag_o == 0, "R4 no overflow on the way to 0xFFFF", ovf_flag_o, 0);
        @(negedge clk);
        chk(count_o == 0 && ovf_flag_o == 0, "R4 wrap to zero without flag", ovf_flag_o, 0);
        wait_count(16'h0040);
        @(negedge clk);
        chk(count_o == 0 && ovf_flag_o, "R4 restart at new capture TOP", count_o, 0);

        // Tick held low: counter frozen, writes still accepted.
        tick_mode = 2;
        @(negedge clk);
        @(negedge clk);
        begin
            logic [15:0] held;
            held = count_o;
            wr(4, 16'h0200);
            repeat (20) @(negedge clk);
            chk(count_o == held, "R8 counter frozen without tick", count_o, held);
        end
        tick_mode = 0;
        wait_count(16'h0200);
        wr(5, 16'h0001);
        chk(count_o == 0, "R8 write during idle took effect", count_o, 0);
        chk(ovf_flag_o == 1, "R9 set wins over clear", ovf_flag_o, 1);

        // Random ticks, checked against the model.
        tick_mode = 1;
        repeat (3000) @(negedge clk);
        tick_mode = 0;
        repeat (4) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule